// File: doc/BRIEF.md
# CAN Mode and Bit-Timing Controller

This block holds the control word, the status word and the bit-timing word of a CAN controller. The control word requests an operating mode through a two-bit field: run, reset, halt or forced reset. A separate sleep flag gates whether the controller may enter the running state. An ordinary request takes effect a fixed number of clocks after it is written. A forced reset takes effect on the next clock. Software therefore writes a request and then polls the status word until the matching flag appears.

The bit-timing word packs four fields: first time segment, prescaler, jump width and second time segment. Each field holds its quantum count minus one. The block presents the real counts to the protocol engine. The word can only be written while the controller is in reset mode. A bus-off event from the protocol engine can move a running controller straight into halt, when the recovery field asks for that.

The register port is a plain single-cycle write strobe with a combinational read. It carries no stream data, so it has no valid/ready pair and never applies back-pressure.

Top module: `canmode_ctrl`

## Requirements
- R1: After reset, the control word reads 0x0500 (sleep flag set, mode field 01), the status word reads 0x0500, the bit-timing word reads 0x00300001, and the mode output shows sleep.
- R2: The mode output codes are 0 run, 1 reset, 2 halt and 3 sleep; sleep is shown whenever control bit 10 is set. Status bit 8 is 1 in reset mode, bit 9 is 1 in halt mode and bit 10 mirrors the sleep flag.
- R3: A write of mode field (control bits 9:8) 00, 01 or 10 changes the effective mode exactly LATENCY clocks after the write edge, and not earlier.
- R4: Mode field 11 (forced reset) puts the controller in reset mode on the clock after it is stored.
- R5: A request for run mode (field 00) made while the sleep flag is set does not take effect; the controller stays in its current mode.
- R6: A bit-timing write in reset mode stores the fields at bits 23:20, 17:8, 5:4 and 2:0. The outputs give each field plus one.
- R7: A bit-timing write with a first-segment field below 3 stores 3 (4 quanta). A write with a second-segment field of 0 stores 1 (2 quanta).
- R8: A bit-timing write made outside reset mode is ignored: the readback and the timing outputs keep their old values.
- R9: With recovery field (control bits 12:11) equal to 01, a bus-off pulse in run mode puts the controller in halt on the next clock, and the stored mode field becomes 10.
- R10: With any recovery field value other than 01, a bus-off pulse leaves both the mode and the control word unchanged.
- R11: When a control write and a bus-off halt fall in the same clock, the written value is stored, except that its mode field is replaced by 10.
- R12: Control bit 0 drives the FIFO-mode output, bit 3 drives the overrun-on-loss output and bits 2:1 drive the ID-format output (10 = mixed). Control bits outside 12:8 and 3:0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address: 0 control, 2 bit-timing |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address: 0 control, 1 status, 2 bit-timing |
| reg_rdata | output | 32 | Read data, combinational |
| busoff_i | input | 1 | Bus-off entry pulse from the protocol engine |
| mode_o | output | 2 | Effective mode code |
| in_reset_o | output | 1 | Controller is in reset mode |
| fifo_mode_o | output | 1 | FIFO mailbox mode selected |
| lost_overrun_o | output | 1 | Overrun selected on message loss |
| idfmt_o | output | 2 | ID format selection |
| tseg1_tq_o | output | 5 | First time segment in quanta |
| brp_div_o | output | 11 | Prescaler divide value |
| sjw_tq_o | output | 3 | Jump width in quanta |
| tseg2_tq_o | output | 4 | Second time segment in quanta |

## Verification
A CPU write to the control word and a bus-off halt can land on the same clock edge. The bench provokes this by raising the bus-off pulse in the same cycle as a control write that changes the ID format. The scoreboard then expects the written configuration with the mode field forced to halt, and expects halt mode on the next clock. A forced-reset request can also coincide with a pending ordinary transition. This is judged by expecting reset one clock after the write, against the LATENCY-clock wait of an ordinary reset request.

// File: rtl/canmode_pkg.sv
package canmode_pkg;
  typedef enum logic [1:0] {
    MODE_OPER  = 2'd0,
    MODE_RESET = 2'd1,
    MODE_HALT  = 2'd2,
    MODE_SLEEP = 2'd3
  } mode_e;

  localparam int TS1_W   = 4;
  localparam int BRP_W   = 10;
  localparam int SJW_W   = 2;
  localparam int TS2_W   = 3;
  localparam int TS1_LSB = 20;
  localparam int BRP_LSB = 8;
  localparam int SJW_LSB = 4;
  localparam int TS2_LSB = 0;
  localparam int TS1_MIN = 4;
  localparam int TS2_MIN = 2;

  localparam int CTL_W        = 16;
  localparam int CTL_FIFO     = 0;
  localparam int CTL_IDF_LSB  = 1;
  localparam int CTL_LOSS     = 3;
  localparam int CTL_MODE_LSB = 8;
  localparam int CTL_SLEEP    = 10;
  localparam int CTL_BOM_LSB  = 11;
  localparam logic [CTL_W-1:0] CTL_MASK  = 16'h1F0F;
  localparam logic [CTL_W-1:0] CTL_RESET = 16'h0500;

  localparam logic [1:0] REQ_OPER  = 2'b00;
  localparam logic [1:0] REQ_HALT  = 2'b10;
  localparam logic [1:0] REQ_FORCE = 2'b11;
  localparam logic [1:0] BOM_HALT  = 2'b01;
endpackage

// File: rtl/canmode_seq.sv
module canmode_seq
  import canmode_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_i,
  input  logic       sleep_i,
  input  logic [1:0] bom_i,
  input  logic       busoff_i,
  output mode_e      cur_o,
  output logic       bo_halt_o
);
  localparam int CW = $clog2(LATENCY + 1);
  localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);

  mode_e          cur_q;
  mode_e          target;
  logic [CW-1:0]  cnt_q;
  logic           force_rst;
  logic           pending;

  always_comb begin
    case (req_i)
      REQ_OPER: target = MODE_OPER;
      REQ_HALT: target = MODE_HALT;
      default:  target = MODE_RESET;
    endcase
  end

  assign force_rst = (req_i == REQ_FORCE);
  assign bo_halt_o = busoff_i && (bom_i == BOM_HALT) && (cur_q == MODE_OPER) && !force_rst;
  assign pending   = (target != cur_q) && !((target == MODE_OPER) && sleep_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= MODE_RESET;
      cnt_q <= '0;
    end else if (force_rst) begin
      cur_q <= MODE_RESET;
      cnt_q <= '0;
    end else if (bo_halt_o) begin
      cur_q <= MODE_HALT;
      cnt_q <= '0;
    end else if (pending) begin
      if (cnt_q == LAST) begin
        cur_q <= target;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign cur_o = cur_q;

  a_r5_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != MODE_OPER && sleep_i) |=> (cur_q != MODE_OPER));

  a_r4_force_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == REQ_FORCE) |=> (cur_q == MODE_RESET));

  a_r9_busoff_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff_i && bom_i == BOM_HALT && cur_q == MODE_OPER && req_i != REQ_FORCE)
      |=> (cur_q == MODE_HALT));

  a_r10_busoff_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff_i && bom_i != BOM_HALT && cur_q == MODE_OPER && req_i == REQ_OPER)
      |=> (cur_q == MODE_OPER));
endmodule

// File: rtl/canmode_btcfg.sv
module canmode_btcfg
  import canmode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             allow_i,
  input  logic [TS1_W-1:0] ts1_i,
  input  logic [BRP_W-1:0] brp_i,
  input  logic [SJW_W-1:0] sjw_i,
  input  logic [TS2_W-1:0] ts2_i,
  output logic [31:0]      cfg_o,
  output logic [TS1_W:0]   ts1_tq_o,
  output logic [BRP_W:0]   brp_o,
  output logic [SJW_W:0]   sjw_tq_o,
  output logic [TS2_W:0]   ts2_tq_o
);
  localparam logic [TS1_W-1:0] TS1_FLOOR = TS1_W'(TS1_MIN - 1);
  localparam logic [TS2_W-1:0] TS2_FLOOR = TS2_W'(TS2_MIN - 1);

  logic [TS1_W-1:0] ts1_q;
  logic [BRP_W-1:0] brp_q;
  logic [SJW_W-1:0] sjw_q;
  logic [TS2_W-1:0] ts2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts1_q <= TS1_FLOOR;
      brp_q <= '0;
      sjw_q <= '0;
      ts2_q <= TS2_FLOOR;
    end else if (wr_i && allow_i) begin
      ts1_q <= (ts1_i < TS1_FLOOR) ? TS1_FLOOR : ts1_i;
      brp_q <= brp_i;
      sjw_q <= sjw_i;
      ts2_q <= (ts2_i < TS2_FLOOR) ? TS2_FLOOR : ts2_i;
    end
  end

  always_comb begin
    cfg_o = '0;
    cfg_o[TS1_LSB +: TS1_W] = ts1_q;
    cfg_o[BRP_LSB +: BRP_W] = brp_q;
    cfg_o[SJW_LSB +: SJW_W] = sjw_q;
    cfg_o[TS2_LSB +: TS2_W] = ts2_q;
  end

  assign ts1_tq_o = {1'b0, ts1_q} + 1'b1;
  assign brp_o    = {1'b0, brp_q} + 1'b1;
  assign sjw_tq_o = {1'b0, sjw_q} + 1'b1;
  assign ts2_tq_o = {1'b0, ts2_q} + 1'b1;

  a_r8_hold_outside_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !allow_i) |=> $stable(cfg_o));

  a_r7_segment_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ts1_tq_o) >= TS1_MIN) && (int'(ts2_tq_o) >= TS2_MIN));
endmodule

// File: rtl/canmode_ctrl.sv
module canmode_ctrl
  import canmode_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_waddr,
  input  logic [31:0] reg_wdata,
  input  logic [1:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  input  logic        busoff_i,
  output logic [1:0]  mode_o,
  output logic        in_reset_o,
  output logic        fifo_mode_o,
  output logic        lost_overrun_o,
  output logic [1:0]  idfmt_o,
  output logic [4:0]  tseg1_tq_o,
  output logic [10:0] brp_div_o,
  output logic [2:0]  sjw_tq_o,
  output logic [3:0]  tseg2_tq_o
);
  logic [CTL_W-1:0] ctrl_q;
  logic [CTL_W-1:0] ctrl_nxt;
  mode_e            cur;
  logic             bo_halt;
  logic             wr_ctl;
  logic             wr_bt;
  logic [31:0]      bt_word;
  logic [31:0]      status;
  logic             sleep;
  logic             unused_wbits;

  assign wr_ctl = reg_wr && (reg_waddr == 2'd0);
  assign wr_bt  = reg_wr && (reg_waddr == 2'd2);
  assign sleep  = ctrl_q[CTL_SLEEP];
  assign unused_wbits = ^{reg_wdata[31:24], reg_wdata[19:18], reg_wdata[7:6], reg_wdata[3]};

  always_comb begin
    ctrl_nxt = wr_ctl ? (reg_wdata[CTL_W-1:0] & CTL_MASK) : ctrl_q;
    if (bo_halt) ctrl_nxt[CTL_MODE_LSB +: 2] = REQ_HALT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTL_RESET;
    else        ctrl_q <= ctrl_nxt;
  end

  canmode_seq #(.LATENCY(LATENCY)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (ctrl_q[CTL_MODE_LSB +: 2]),
    .sleep_i   (sleep),
    .bom_i     (ctrl_q[CTL_BOM_LSB +: 2]),
    .busoff_i  (busoff_i),
    .cur_o     (cur),
    .bo_halt_o (bo_halt)
  );

  canmode_btcfg u_bt (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_bt),
    .allow_i  (cur == MODE_RESET),
    .ts1_i    (reg_wdata[TS1_LSB +: TS1_W]),
    .brp_i    (reg_wdata[BRP_LSB +: BRP_W]),
    .sjw_i    (reg_wdata[SJW_LSB +: SJW_W]),
    .ts2_i    (reg_wdata[TS2_LSB +: TS2_W]),
    .cfg_o    (bt_word),
    .ts1_tq_o (tseg1_tq_o),
    .brp_o    (brp_div_o),
    .sjw_tq_o (sjw_tq_o),
    .ts2_tq_o (tseg2_tq_o)
  );

  always_comb begin
    status     = '0;
    status[8]  = (cur == MODE_RESET);
    status[9]  = (cur == MODE_HALT);
    status[10] = sleep;
  end

  always_comb begin
    case (reg_raddr)
      2'd0:    reg_rdata = {{(32-CTL_W){1'b0}}, ctrl_q};
      2'd1:    reg_rdata = status;
      2'd2:    reg_rdata = bt_word;
      default: reg_rdata = '0;
    endcase
  end

  assign mode_o         = sleep ? MODE_SLEEP : cur;
  assign in_reset_o     = (cur == MODE_RESET);
  assign fifo_mode_o    = ctrl_q[CTL_FIFO];
  assign lost_overrun_o = ctrl_q[CTL_LOSS];
  assign idfmt_o        = ctrl_q[CTL_IDF_LSB +: 2];

  a_r11_halt_field_written: assert property (@(posedge clk) disable iff (!rst_n)
    bo_halt |=> (ctrl_q[CTL_MODE_LSB +: 2] == REQ_HALT));

  a_r12_masked_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~CTL_MASK) == '0);
endmodule

// File: tb/canmode_ctrl_bench.sv
module canmode_ctrl_bench;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        busoff = 1'b0;
  logic [1:0]  mode;
  logic        in_reset, fifo_mode, lost_ovr;
  logic [1:0]  idfmt;
  logic [4:0]  t1;
  logic [10:0] brp;
  logic [2:0]  sjw;
  logic [3:0]  t2;

  canmode_ctrl #(.LATENCY(LAT)) u_canmode_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .busoff_i(busoff), .mode_o(mode), .in_reset_o(in_reset),
    .fifo_mode_o(fifo_mode), .lost_overrun_o(lost_ovr), .idfmt_o(idfmt),
    .tseg1_tq_o(t1), .brp_div_o(brp), .sjw_tq_o(sjw), .tseg2_tq_o(t2)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int          cyc;
    int          sel;
    logic [1:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] tpk(int a, int b, int c, int d);
    logic [4:0] x1 = 5'(a);
    logic [10:0] x2 = 11'(b);
    logic [2:0] x3 = 3'(c);
    logic [3:0] x4 = 4'(d);
    return {9'd0, x1, x2, x3, x4};
  endfunction

  task automatic expect_at(int off, int sel, logic [1:0] addr, logic [31:0] v, string tag);
    item_t it;
    it.cyc = cyc + off; it.sel = sel; it.addr = addr; it.exp = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic op(bit w, logic [1:0] a, logic [31:0] d, bit bo);
    @(negedge clk);
    reg_wr = w; reg_waddr = a; reg_wdata = d; busoff = bo;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; busoff = 1'b0;
  endtask

  // monitor: pops expectations and compares at their cycle
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        item_t it;
        logic [31:0] obs;
        it = q.pop_front();
        if (it.sel == 1) begin
          reg_raddr = it.addr;
          #0.5;
        end
        case (it.sel)
          0: obs = {30'd0, mode};
          1: obs = reg_rdata;
          2: obs = tpk(int'(t1), int'(brp), int'(sjw), int'(t2));
          default: obs = {28'd0, fifo_mode, lost_ovr, idfmt};
        endcase
        n_chk++;
        if (it.cyc != cyc || obs !== it.exp) begin
          n_bad++;
          $display("FAIL %s sel%0d at cycle %0d (due %0d): actual %h expected %h",
                   it.tag, it.sel, cyc, it.cyc, obs, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_at(1, 1, 2'd0, 32'h0500, "R1 ctrl");
    expect_at(1, 1, 2'd1, 32'h0500, "R1 status");
    expect_at(1, 1, 2'd2, 32'h0030_0001, "R1 bitcfg");
    expect_at(1, 0, 2'd0, 32'd3, "R1 mode sleep");
    expect_at(1, 2, 2'd0, tpk(4, 1, 1, 2), "R1 timing");
    drain();
    // R6 bit-timing write in reset
    op(1, 2'd2, 32'h0070_0923, 0);
    expect_at(1, 2, 2'd0, tpk(8, 10, 3, 4), "R6 timing");
    expect_at(1, 1, 2'd2, 32'h0070_0923, "R6 readback");
    drain();
    // R7 clamping
    op(1, 2'd2, 32'h0010_0000, 0);
    expect_at(1, 2, 2'd0, tpk(4, 1, 1, 2), "R7 timing");
    expect_at(1, 1, 2'd2, 32'h0030_0001, "R7 readback");
    drain();
    op(1, 2'd2, 32'h0070_0923, 0);
    drain();
    // R5 run request while sleeping
    op(1, 2'd0, 32'h0400, 0);
    expect_at(LAT + 2, 1, 2'd1, 32'h0500, "R5 status");
    expect_at(LAT + 3, 0, 2'd0, 32'd3, "R5 mode");
    drain();
    // R3 / R12 wake and run; masked bits dropped
    op(1, 2'd0, 32'hE8FD, 0);
    expect_at(LAT - 1, 1, 2'd1, 32'h0100, "R3 before latency");
    expect_at(LAT - 1, 0, 2'd0, 32'd1, "R2 mode reset");
    expect_at(LAT, 1, 2'd1, 32'h0000, "R3 at latency");
    expect_at(LAT, 0, 2'd0, 32'd0, "R2 mode run");
    expect_at(LAT + 1, 1, 2'd0, 32'h080D, "R12 ctrl mask");
    expect_at(LAT + 1, 3, 2'd0, 32'hE, "R12 config outputs");
    drain();
    // R8 bit-timing write outside reset ignored
    op(1, 2'd2, 32'h00F3_FF37, 0);
    expect_at(1, 2, 2'd0, tpk(8, 10, 3, 4), "R8 timing");
    expect_at(1, 1, 2'd2, 32'h0070_0923, "R8 readback");
    drain();
    // R9 bus-off to halt
    op(0, 2'd0, 32'h0, 1);
    expect_at(1, 0, 2'd0, 32'd2, "R9 mode halt");
    expect_at(1, 1, 2'd1, 32'h0200, "R9 status halt");
    expect_at(1, 1, 2'd0, 32'h0A0D, "R9 field rewritten");
    drain();
    op(1, 2'd0, 32'h080D, 0);
    expect_at(LAT - 1, 0, 2'd0, 32'd2, "R3 halt held");
    expect_at(LAT, 0, 2'd0, 32'd0, "R3 back to run");
    drain();
    // R10 bus-off ignored with other recovery setting
    op(1, 2'd0, 32'h000D, 0);
    drain();
    op(0, 2'd0, 32'h0, 1);
    expect_at(2, 0, 2'd0, 32'd0, "R10 mode run");
    expect_at(2, 1, 2'd0, 32'h000D, "R10 ctrl unchanged");
    drain();
    // R11 same-cycle write and bus-off halt
    op(1, 2'd0, 32'h080D, 0);
    drain();
    op(1, 2'd0, 32'h0809, 1);
    expect_at(1, 1, 2'd0, 32'h0A09, "R11 ctrl merged");
    expect_at(1, 0, 2'd0, 32'd2, "R11 mode halt");
    drain();
    // R3 ordinary reset request waits; R4 forced reset immediate
    op(1, 2'd0, 32'h0109, 0);
    expect_at(LAT - 1, 1, 2'd1, 32'h0200, "R3 reset pending");
    expect_at(LAT, 1, 2'd1, 32'h0100, "R3 reset entered");
    drain();
    op(1, 2'd0, 32'h0009, 0);
    expect_at(LAT, 0, 2'd0, 32'd0, "R3 run again");
    drain();
    op(1, 2'd0, 32'h0309, 0);
    expect_at(1, 1, 2'd1, 32'h0100, "R4 forced reset");
    expect_at(1, 0, 2'd0, 32'd1, "R4 mode reset");
    drain();
    op(1, 2'd0, 32'h0709, 0);
    expect_at(1, 0, 2'd0, 32'd3, "R2 sleep shown");
    expect_at(1, 1, 2'd1, 32'h0500, "R2 status sleep");
    drain();
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule